// File: doc/BRIEF.md
# Per-Beat DMA Address Generator

This block walks the source and destination addresses of one DMA channel, one beat at a time. A start pulse captures two base addresses, an addressing mode for each side, two strides, a device width choice, a frame length in bytes and a frame count. After that, each accepted beat handshake advances both pointers. It also lowers the count of bytes left in the current frame and raises single-cycle events at the half-frame point, at each frame end and at the end of the final frame.

Each side picks its addressing on its own. A fixed side keeps its address for the whole run, which suits a device FIFO. An incrementing side walks through memory without a break. A strided side walks through memory inside a frame, then jumps at each frame boundary to the previous frame's start plus its stride.

A beat moves 4 bytes, or 1 byte when narrow width is chosen. The last beat of a frame is shortened to whatever is left. The surrounding engine reports the size of each beat to the bus.

Top module: `dma_addr_gen`

## Requirements
- R1: While rst_ni is low, and until the first start, busy_o, every event output, remain_o, beat_bytes_o and both pointers read 0.
- R2: A start_i pulse while idle loads src_ptr_o and dst_ptr_o with their bases, loads remain_o with frame_len_i and raises busy_o, all visible in the cycle after the start edge.
- R3: Mode value 0 on a side, and the unused value 3, is fixed addressing: that side's pointer does not move on any beat.
- R4: Mode value 1 is incrementing addressing: each beat adds the beat size to the pointer, and the pointer continues across frame boundaries without a jump.
- R5: Mode value 2 is strided addressing: inside a frame, each beat adds the beat size. On the beat that ends a frame, the pointer becomes that frame's start address plus the side's stride, taken modulo 2^ADDR_W.
- R6: beat_bytes_o is the smaller of remain_o and the beat size. The beat size is 4 when byte_wide_i was 0 at start and 1 when it was 1. Each accepted beat lowers remain_o by beat_bytes_o.
- R7: frame_evt_o pulses for exactly one cycle after the beat that brings the remaining count to zero. If frames are left, remain_o reloads to the frame length in the same cycle.
- R8: half_evt_o pulses once per frame, one cycle after the first beat that leaves the remaining count at or below floor(frame length / 2).
- R9: On the final frame, last_evt_o pulses together with frame_evt_o and busy_o falls in that cycle. A frame count of 0 runs exactly one frame.
- R10: start_i while busy and beat_ack_i while idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture configuration and begin a run (ignored while busy) |
| src_base_i | input | ADDR_W | Source base address |
| dst_base_i | input | ADDR_W | Destination base address |
| src_mode_i | input | 2 | Source addressing: 0 fixed, 1 incrementing, 2 strided, 3 fixed |
| dst_mode_i | input | 2 | Destination addressing, same encoding |
| src_stride_i | input | ADDR_W | Source jump between frame starts in strided mode |
| dst_stride_i | input | ADDR_W | Destination jump between frame starts in strided mode |
| byte_wide_i | input | 1 | 1 selects 1-byte beats, 0 selects 4-byte beats |
| frame_len_i | input | FLEN_W | Frame length in bytes, nonzero |
| frame_cnt_i | input | FCNT_W | Number of frames, 0 counts as 1 |
| beat_ack_i | input | 1 | A beat was accepted this cycle |
| busy_o | output | 1 | A run is in progress |
| src_ptr_o | output | ADDR_W | Current source address |
| dst_ptr_o | output | ADDR_W | Current destination address |
| remain_o | output | FLEN_W | Bytes left in the current frame |
| beat_bytes_o | output | 3 | Byte count of the current beat |
| frame_evt_o | output | 1 | One-cycle pulse after a frame completes |
| half_evt_o | output | 1 | One-cycle pulse at the half-frame point |
| last_evt_o | output | 1 | One-cycle pulse after the final frame completes |

## Verification
The properties assume that a run starts with a nonzero frame length. A zero-length frame would leave the generator busy with nothing to count. The properties also expect beat_ack_i to be honoured only while busy_o is high, and configuration inputs to matter only at the start edge. The stimulus draws frame lengths from 1 to 40 bytes so that short final beats and one-beat frames appear often. It changes configuration inputs freely mid-run, pulses start_i during runs and beat_ack_i after them, and gates acknowledgements at random so that idle gaps fall between beats.

// File: rtl/dma_addr_gen_pkg.sv
package dma_addr_gen_pkg;
  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_INCR   = 2'd1,
    AM_STRIDE = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  localparam int unsigned BEAT_W = 3;
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_addr_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [1:0]              mode_i,
  input  logic [ADDR_W-1:0]       stride_i,
  input  logic                    step_i,
  input  logic [BEAT_W-1:0]       beat_bytes_i,
  input  logic                    frame_end_i,
  output logic [ADDR_W-1:0]       ptr_o
);
  addr_mode_e        mode_q;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] fstart_q;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] next_start;

  assign ptr_inc    = ptr_q + ADDR_W'(beat_bytes_i);
  assign next_start = fstart_q + stride_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= AM_FIXED;
      stride_q <= '0;
      ptr_q    <= '0;
      fstart_q <= '0;
    end else if (load_i) begin
      mode_q   <= addr_mode_e'(mode_i);
      stride_q <= stride_i;
      ptr_q    <= base_i;
      fstart_q <= base_i;
    end else if (step_i) begin
      unique case (mode_q)
        AM_INCR: ptr_q <= ptr_inc;
        AM_STRIDE: begin
          if (frame_end_i) begin
            ptr_q    <= next_start;
            fstart_q <= next_start;
          end else begin
            ptr_q <= ptr_inc;
          end
        end
        default: ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dma_frame_ctr.sv
module dma_frame_ctr
  import dma_addr_gen_pkg::*;
#(
  parameter int unsigned FLEN_W = 20,
  parameter int unsigned FCNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FLEN_W-1:0] len_i,
  input  logic [FCNT_W-1:0] cnt_i,
  input  logic              wide_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic [FLEN_W-1:0] remain_o,
  output logic [BEAT_W-1:0] beat_bytes_o,
  output logic              step_o,
  output logic              frame_end_o,
  output logic              frame_evt_o,
  output logic              half_evt_o,
  output logic              last_evt_o
);
  logic [FLEN_W-1:0] remain_q, len_q, rem_nxt, half_lvl;
  logic [FCNT_W-1:0] frames_q;
  logic              narrow_q, busy_q, half_done_q;
  logic              fevt_q, hevt_q, levt_q;
  logic [BEAT_W-1:0] step_sz, bb;

  assign step_sz  = narrow_q ? BEAT_W'(1) : BEAT_W'(4);
  assign bb       = (remain_q < FLEN_W'(step_sz)) ? remain_q[BEAT_W-1:0] : step_sz;
  assign rem_nxt  = remain_q - FLEN_W'(bb);
  assign half_lvl = len_q >> 1;
  assign step_o      = busy_q & ack_i;
  assign frame_end_o = step_o && (rem_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q    <= '0;
      len_q       <= '0;
      frames_q    <= '0;
      narrow_q    <= 1'b0;
      busy_q      <= 1'b0;
      half_done_q <= 1'b0;
      fevt_q      <= 1'b0;
      hevt_q      <= 1'b0;
      levt_q      <= 1'b0;
    end else begin
      fevt_q <= 1'b0;
      hevt_q <= 1'b0;
      levt_q <= 1'b0;
      if (load_i) begin
        remain_q    <= len_i;
        len_q       <= len_i;
        frames_q    <= (cnt_i == '0) ? FCNT_W'(1) : cnt_i;
        narrow_q    <= wide_i;
        busy_q      <= 1'b1;
        half_done_q <= 1'b0;
      end else if (step_o) begin
        remain_q <= rem_nxt;
        if (!half_done_q && (rem_nxt <= half_lvl)) begin
          hevt_q      <= 1'b1;
          half_done_q <= 1'b1;
        end
        if (rem_nxt == '0) begin
          fevt_q <= 1'b1;
          if (frames_q == FCNT_W'(1)) begin
            levt_q   <= 1'b1;
            busy_q   <= 1'b0;
            frames_q <= '0;
          end else begin
            frames_q    <= frames_q - FCNT_W'(1);
            remain_q    <= len_q;
            half_done_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign remain_o     = remain_q;
  assign beat_bytes_o = bb;
  assign frame_evt_o  = fevt_q;
  assign half_evt_o   = hevt_q;
  assign last_evt_o   = levt_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FLEN_W = 20,
  parameter int unsigned FCNT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [1:0]        src_mode_i,
  input  logic [1:0]        dst_mode_i,
  input  logic [ADDR_W-1:0] src_stride_i,
  input  logic [ADDR_W-1:0] dst_stride_i,
  input  logic              byte_wide_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic [FCNT_W-1:0] frame_cnt_i,
  input  logic              beat_ack_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] src_ptr_o,
  output logic [ADDR_W-1:0] dst_ptr_o,
  output logic [FLEN_W-1:0] remain_o,
  output logic [2:0]        beat_bytes_o,
  output logic              frame_evt_o,
  output logic              half_evt_o,
  output logic              last_evt_o
);
  localparam int unsigned NSIDE = 2;

  logic              load, step, frame_end, busy;
  logic [BEAT_W-1:0] bb;
  logic [ADDR_W-1:0] base_a   [NSIDE];
  logic [ADDR_W-1:0] stride_a [NSIDE];
  logic [1:0]        mode_a   [NSIDE];
  logic [ADDR_W-1:0] ptr_a    [NSIDE];

  assign load = start_i & ~busy;

  assign base_a[0]   = src_base_i;
  assign base_a[1]   = dst_base_i;
  assign stride_a[0] = src_stride_i;
  assign stride_a[1] = dst_stride_i;
  assign mode_a[0]   = src_mode_i;
  assign mode_a[1]   = dst_mode_i;

  dma_frame_ctr #(
    .FLEN_W(FLEN_W),
    .FCNT_W(FCNT_W)
  ) ctr_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .len_i        (frame_len_i),
    .cnt_i        (frame_cnt_i),
    .wide_i       (byte_wide_i),
    .ack_i        (beat_ack_i),
    .busy_o       (busy),
    .remain_o     (remain_o),
    .beat_bytes_o (bb),
    .step_o       (step),
    .frame_end_o  (frame_end),
    .frame_evt_o  (frame_evt_o),
    .half_evt_o   (half_evt_o),
    .last_evt_o   (last_evt_o)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_side #(
      .ADDR_W(ADDR_W)
    ) side_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (load),
      .base_i       (base_a[g]),
      .mode_i       (mode_a[g]),
      .stride_i     (stride_a[g]),
      .step_i       (step),
      .beat_bytes_i (bb),
      .frame_end_i  (frame_end),
      .ptr_o        (ptr_a[g])
    );
  end

  assign busy_o       = busy;
  assign src_ptr_o    = ptr_a[0];
  assign dst_ptr_o    = ptr_a[1];
  assign beat_bytes_o = bb;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FLEN_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              beat_ack_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] src_ptr_o,
  input logic [ADDR_W-1:0] dst_ptr_o,
  input logic [FLEN_W-1:0] remain_o,
  input logic [2:0]        beat_bytes_o,
  input logic              frame_evt_o,
  input logic              half_evt_o,
  input logic              last_evt_o
);
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(src_ptr_o) && $stable(dst_ptr_o) && $stable(remain_o)));

  assert_busy_beat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (remain_o != '0 && beat_bytes_o != 3'd0 && beat_bytes_o <= 3'd4));

  assert_remain_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && beat_ack_i && (remain_o > FLEN_W'(beat_bytes_o)))
      |=> (remain_o == $past(remain_o) - FLEN_W'($past(beat_bytes_o))));

  assert_frame_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt_o |-> $past(busy_o && beat_ack_i));

  assert_half_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_evt_o |-> $past(busy_o && beat_ack_i));

  assert_last_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_evt_o |-> (frame_evt_o && !busy_o));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(
  .ADDR_W(ADDR_W),
  .FLEN_W(FLEN_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .beat_ack_i   (beat_ack_i),
  .busy_o       (busy_o),
  .src_ptr_o    (src_ptr_o),
  .dst_ptr_o    (dst_ptr_o),
  .remain_o     (remain_o),
  .beat_bytes_o (beat_bytes_o),
  .frame_evt_o  (frame_evt_o),
  .half_evt_o   (half_evt_o),
  .last_evt_o   (last_evt_o)
);

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned FW = 20;
  localparam int unsigned CW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
  logic [1:0]    src_mode_i = '0, dst_mode_i = '0;
  logic [AW-1:0] src_stride_i = '0, dst_stride_i = '0;
  logic          byte_wide_i = 1'b0;
  logic [FW-1:0] frame_len_i = '0;
  logic [CW-1:0] frame_cnt_i = '0;
  logic          beat_ack_i = 1'b0;
  logic          busy_o;
  logic [AW-1:0] src_ptr_o, dst_ptr_o;
  logic [FW-1:0] remain_o;
  logic [2:0]    beat_bytes_o;
  logic          frame_evt_o, half_evt_o, last_evt_o;

  always #4 clk_i = ~clk_i;

  dma_addr_gen #(.ADDR_W(AW), .FLEN_W(FW), .FCNT_W(CW)) dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference state
  logic [AW-1:0] m_ptr [2], m_fs [2], m_str [2];
  logic [1:0]    m_mode [2];
  int            m_rem, m_len, m_frames;
  bit            m_wide, m_busy, m_hf, m_fe, m_he, m_le;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_bb();
    int step = m_wide ? 1 : 4;
    return (m_rem < step) ? m_rem : step;
  endfunction

  function automatic string mode_tag(logic [1:0] md);
    if (md == 2'd1) return "R4";
    if (md == 2'd2) return "R5";
    return "R3";
  endfunction

  task automatic check_all(string tag);
    chk((tag != "") ? tag : mode_tag(m_mode[0]), "src_ptr", src_ptr_o, m_ptr[0]);
    chk((tag != "") ? tag : mode_tag(m_mode[1]), "dst_ptr", dst_ptr_o, m_ptr[1]);
    chk((tag != "") ? tag : "R6", "remain", remain_o, m_rem);
    chk((tag != "") ? tag : "R6", "beat_bytes", beat_bytes_o, exp_bb());
    chk((tag != "") ? tag : "R9", "busy", busy_o, m_busy);
    chk((tag != "") ? tag : "R7", "frame_evt", frame_evt_o, m_fe);
    chk((tag != "") ? tag : "R8", "half_evt", half_evt_o, m_he);
    chk((tag != "") ? tag : "R9", "last_evt", last_evt_o, m_le);
  endtask

  task automatic model_tick(bit ack);
    m_fe = 0; m_he = 0; m_le = 0;
    if (ack && m_busy) begin
      int bb = exp_bb();
      int rn = m_rem - bb;
      for (int s = 0; s < 2; s++) begin
        if (m_mode[s] == 2'd1) m_ptr[s] = m_ptr[s] + AW'(bb);
        else if (m_mode[s] == 2'd2) begin
          if (rn == 0) begin
            m_fs[s]  = m_fs[s] + m_str[s];
            m_ptr[s] = m_fs[s];
          end else m_ptr[s] = m_ptr[s] + AW'(bb);
        end
      end
      m_rem = rn;
      if (!m_hf && rn <= m_len / 2) begin m_he = 1; m_hf = 1; end
      if (rn == 0) begin
        m_fe = 1;
        if (m_frames == 1) begin m_le = 1; m_busy = 0; m_frames = 0; end
        else begin m_frames--; m_rem = m_len; m_hf = 0; end
      end
    end
  endtask

  task automatic cycle(bit ack, string tag);
    beat_ack_i = ack;
    model_tick(ack);
    @(negedge clk_i);
    check_all(tag);
  endtask

  task automatic start_run(logic [AW-1:0] sb, logic [AW-1:0] db, logic [1:0] sm, logic [1:0] dm,
                           logic [AW-1:0] ss, logic [AW-1:0] ds, bit w, int len, int cnt, string tag);
    src_base_i = sb; dst_base_i = db; src_mode_i = sm; dst_mode_i = dm;
    src_stride_i = ss; dst_stride_i = ds; byte_wide_i = w;
    frame_len_i = FW'(len); frame_cnt_i = CW'(cnt);
    start_i = 1'b1; beat_ack_i = 1'b0;
    m_fe = 0; m_he = 0; m_le = 0;
    if (!m_busy) begin
      m_ptr[0] = sb; m_ptr[1] = db; m_fs[0] = sb; m_fs[1] = db;
      m_mode[0] = sm; m_mode[1] = dm; m_str[0] = ss; m_str[1] = ds;
      m_wide = w; m_rem = len; m_len = len; m_frames = (cnt == 0) ? 1 : cnt;
      m_busy = 1; m_hf = 0;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    check_all(tag);
  endtask

  task automatic run_out(int pct);
    while (m_busy) cycle(($urandom % 100) < pct, "");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_ptr[0] = '0; m_ptr[1] = '0; m_fs[0] = '0; m_fs[1] = '0;
    m_str[0] = '0; m_str[1] = '0; m_mode[0] = '0; m_mode[1] = '0;
    m_rem = 0; m_len = 0; m_frames = 0;
    m_wide = 0; m_busy = 0; m_hf = 0; m_fe = 0; m_he = 0; m_le = 0;

    // R1: reset state
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // R2 R4 R3: incr source, fixed dest, 4-byte beats, len 10 -> 4,4,2, two frames
    start_run(32'h1000, 32'h8000_0040, 2'd1, 2'd0, '0, '0, 1'b0, 10, 2, "R2");
    run_out(100);

    // R5: strided both sides, 1-byte beats, negative dest stride
    start_run(32'h2000, 32'h9000, 2'd2, 2'd2, 32'h100, 32'hFFFF_FFC0, 1'b1, 5, 3, "R2");
    run_out(60);

    // R9: frame count 0 runs one frame; R3 with reserved mode 3
    start_run(32'hA0, 32'hB0, 2'd3, 2'd1, 32'h4, 32'h4, 1'b0, 7, 0, "R2");
    run_out(100);

    // R8: frame of one byte, half and frame events together
    start_run(32'h10, 32'h20, 2'd2, 2'd1, 32'h40, 32'h0, 1'b0, 1, 3, "R2");
    run_out(100);

    // R10: start while busy is ignored
    start_run(32'h3000, 32'h4000, 2'd1, 2'd2, 32'h0, 32'h80, 1'b0, 24, 2, "R2");
    cycle(1'b1, "");
    cycle(1'b1, "");
    start_run(32'hDEAD_0000, 32'hBEEF_0000, 2'd0, 2'd0, '0, '0, 1'b1, 3, 1, "R10");
    cycle(1'b0, "R10");
    run_out(80);

    // R10: acks while idle are ignored
    for (int i = 0; i < 4; i++) cycle(1'b1, "R10");

    // constrained random runs
    for (int r = 0; r < 24; r++) begin
      start_run($urandom, $urandom, 2'($urandom % 4), 2'($urandom % 4),
                $urandom, $urandom, 1'($urandom % 2),
                1 + int'($urandom % 40), int'($urandom % 5), "R2");
      run_out(50 + int'($urandom % 50));
      repeat (int'($urandom % 3)) cycle(1'($urandom % 2), "R10");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule